// File: doc/BRIEF.md
# Boot-Strap Capture and External Interrupt Controller

The block owns four active-low external pins, called lines A to D. Each pin has two roles. While the chip-level reset is held low, the pins are configuration straps. The block continually loads a 4-bit operating-mode value from them. When reset is released, that value is frozen and the pins take on their second role as interrupt requests.

In the interrupt role, every line can be masked on its own. Each line can also be set to level-sensitive or falling-edge detection. Edge detections are kept in sticky pending flags until the core acknowledges them. Among the pending lines that are not masked, the block presents one request with a 2-bit line index, and a fixed priority picks which line that is. Line A has a second duty while the core is stopped: pulling it low raises a wake signal, which stays high until the stop state ends.

Every pin passes through a two-stage synchronizer to the core clock before any use. Reset is sampled on the clock.

Top module: `strap_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_q` follows the synchronized pins inverted: bit i is 1 when pin i is low, with A as bit 0. The value is loaded at the last clock edge with `rst_n` low, then held unchanged while reset stays released, whatever the pins do. A pin change shows in `mode_q` three clock edges later.
- R2: An unmasked level-mode line raises `irq_req` two clock edges after its pin goes low. The request drops two edges after the pin returns high.
- R3: On an unmasked edge-mode line, a falling edge of the pin sets a sticky pending flag. The request shows three edges after the fall and remains after the pin returns high.
- R4: Asserting `ack` with `ack_idx` = i clears the edge pending flag of line i only, one edge later. On a level-mode line the acknowledge has no effect.
- R5: A masked line never raises `irq_req`. An edge seen while a line is masked is still recorded, and it raises the request as soon as the mask bit is cleared.
- R6: With several unmasked lines pending, `irq_idx` gives the highest-priority one. The order is A (index 0), then B (1), then C (2), then D (3).
- R7: Edge pending flags are held clear during reset. In the first cycle after reset `irq_req` is low, whatever the pins are.
- R8: With `stop_state` high, a low on pin A raises `wake` three edges later, regardless of the mask. `wake` stays high while `stop_state` stays high, even after the pin returns high. It drops one edge after `stop_state` goes low. Other pins never raise `wake`.
- R9: `cfg_we` loads `cfg_mask` and `cfg_edge` at the next edge. Bit i belongs to line i. A mask bit of 1 masks the line. An edge bit of 1 selects falling-edge detection and 0 selects level. Reset values are all masked and all level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pin_n | input | 4 | Active-low strap and interrupt pins, bit 0 = line A |
| cfg_we | input | 1 | Write strobe for the mask and trigger settings |
| cfg_mask | input | 4 | Mask bits, 1 = line masked |
| cfg_edge | input | 4 | Trigger bits, 1 = falling edge, 0 = level |
| ack | input | 1 | Acknowledge strobe |
| ack_idx | input | 2 | Line being acknowledged |
| stop_state | input | 1 | High while the core is stopped |
| mode_q | output | 4 | Captured operating mode |
| irq_req | output | 1 | An unmasked line is pending |
| irq_idx | output | 2 | Index of the highest-priority pending line |
| wake | output | 1 | Stop-exit request |

## Verification
The assertions take for granted that `ack` is only pulsed for a line the core has just seen in `irq_idx`. They also assume `stop_state` changes only on clock-synchronous boundaries, and that reset is held for at least the synchronizer depth plus one edge, so that the straps have settled before they are frozen. The stimulus drives every input just after a falling clock edge. It keeps reset low for several cycles and pulses `ack` for single cycles. It leaves at least three edges after any pin change before checking a result.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    // Free running: straps must be visible while reset is held.
    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sirq_line.sv
module sirq_line
    import sirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_n,
    input  trig_e trig,
    input  logic  ack_hit,
    output logic  pend_o
);
    typedef struct packed {
        logic prev;
        logic edge_pend;
    } line_t;

    line_t line_d;
    line_t line_q;
    logic  fell;

    always_comb begin
        line_d      = line_q;
        line_d.prev = lvl_n;
        fell        = line_q.prev & ~lvl_n;
        if (trig == TRIG_FALL) begin
            if (ack_hit) begin
                line_d.edge_pend = 1'b0;
            end
            if (fell) begin
                line_d.edge_pend = 1'b1;
            end
        end else begin
            line_d.edge_pend = 1'b0;
        end
        if (!rst_n) begin
            line_d.edge_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        line_q <= line_d;
    end

    assign pend_o = (trig == TRIG_FALL) ? line_q.edge_pend : ~lvl_n;
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_vec,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_vec;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl
    import sirq_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_LINE   = 0,
    localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_n,
    input  logic                 cfg_we,
    input  logic [NUM_LINES-1:0] cfg_mask,
    input  logic [NUM_LINES-1:0] cfg_edge,
    input  logic                 ack,
    input  logic [IDX_W-1:0]     ack_idx,
    input  logic                 stop_state,
    output logic [NUM_LINES-1:0] mode_q,
    output logic                 irq_req,
    output logic [IDX_W-1:0]     irq_idx,
    output logic                 wake
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mode;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] trig;
        logic                 wake;
    } ctl_t;

    ctl_t                 state_d;
    ctl_t                 state_q;
    logic [NUM_LINES-1:0] pin_s;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] req_vec;

    sirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .async_i (pin_n),
        .sync_o  (pin_s)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.mode = ~pin_s;
            state_d.mask = '1;
            state_d.trig = '0;
            state_d.wake = 1'b0;
        end else begin
            if (cfg_we) begin
                state_d.mask = cfg_mask;
                state_d.trig = cfg_edge;
            end
            state_d.wake = stop_state & (state_q.wake | ~pin_s[WAKE_LINE]);
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        sirq_line line_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_n   (pin_s[gi]),
            .trig    (trig_e'(state_q.trig[gi])),
            .ack_hit (ack && (ack_idx == IDX_W'(gi))),
            .pend_o  (pend[gi])
        );
    end

    assign req_vec = pend & ~state_q.mask;

    sirq_prio #(.N(NUM_LINES), .IW(IDX_W)) prio_i (
        .req_vec (req_vec),
        .any_o   (irq_req),
        .idx_o   (irq_idx)
    );

    assign mode_q = state_q.mode;
    assign wake   = state_q.wake;
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  mode,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  req_vec,
    input logic          irq_req,
    input logic [IW-1:0] irq_idx,
    input logic          stop_state,
    input logic          wake
);
    logic [N-1:0] below;

    always_comb begin
        below = '0;
        for (int i = 0; i < N; i++) begin
            if (IW'(i) < irq_idx) begin
                below[i] = req_vec[i];
            end
        end
    end

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_req);

    p_idx_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> req_vec[irq_idx]);

    p_idx_highest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (below == '0));

    p_quiet_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_req);

    p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_state |=> !wake);

    p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && stop_state) |=> wake);
endmodule

bind strap_irq_ctrl sirq_checker #(.N(NUM_LINES), .IW(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .mask       (state_q.mask),
    .req_vec    (req_vec),
    .irq_req    (irq_req),
    .irq_idx    (irq_idx),
    .stop_state (stop_state),
    .wake       (wake)
);

// File: tb/strap_irq_ctrl_tb.sv
module strap_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {pin_n[3:0], mask[3:0], exp_req, exp_idx[1:0]} ; level mode on all lines
    localparam logic [10:0] VEC [NV] = '{
        {4'b1111, 4'b0000, 1'b0, 2'd0},
        {4'b1110, 4'b0000, 1'b1, 2'd0},
        {4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b0000, 4'b0001, 1'b1, 2'd1},
        {4'b0111, 4'b0000, 1'b1, 2'd3},
        {4'b0011, 4'b0000, 1'b1, 2'd2},
        {4'b0011, 4'b0100, 1'b1, 2'd3},
        {4'b0011, 4'b1100, 1'b0, 2'd0},
        {4'b1001, 4'b0000, 1'b1, 2'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin_n;
    logic       cfg_we;
    logic [3:0] cfg_mask;
    logic [3:0] cfg_edge;
    logic       ack;
    logic [1:0] ack_idx;
    logic       stop_state;
    logic [3:0] mode_q;
    logic       irq_req;
    logic [1:0] irq_idx;
    logic       wake;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strap_irq_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (pin_n),
        .cfg_we     (cfg_we),
        .cfg_mask   (cfg_mask),
        .cfg_edge   (cfg_edge),
        .ack        (ack),
        .ack_idx    (ack_idx),
        .stop_state (stop_state),
        .mode_q     (mode_q),
        .irq_req    (irq_req),
        .irq_idx    (irq_idx),
        .wake       (wake)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] m, input logic [3:0] e);
        cfg_mask = m;
        cfg_edge = e;
        cfg_we   = 1'b1;
        step(1);
        cfg_we   = 1'b0;
    endtask

    task automatic pulse_ack(input logic [1:0] idx);
        ack     = 1'b1;
        ack_idx = idx;
        step(1);
        ack     = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin_n = 4'b1010; cfg_we = 1'b0; cfg_mask = 4'b0;
        cfg_edge = 4'b0; ack = 1'b0; ack_idx = 2'd0; stop_state = 1'b0;
        step(4);
        chk("R1 mode follows straps in reset", mode_q, 4'b0101);
        chk("R8 wake low in reset", wake, 0);
        pin_n = 4'b0110;
        step(3);
        chk("R1 mode tracks new straps", mode_q, 4'b1001);
        rst_n = 1'b1;
        step(1);
        chk("R7 no request first cycle after reset", irq_req, 0);
        pin_n = 4'b0000;
        step(4);
        chk("R1 mode frozen after reset", mode_q, 4'b1001);
        chk("R9 reset masks all lines", irq_req, 0);
        write_cfg(4'b0000, 4'b0000);
        chk("R9 unmask level lines raises request", irq_req, 1);
        chk("R9 index after unmask", irq_idx, 0);
        pin_n = 4'b1111;
        step(2);
        chk("R2 request drops two edges after release", irq_req, 0);

        // R2 R5 R6: table of level-mode patterns
        for (int v = 0; v < NV; v++) begin
            pin_n    = VEC[v][10:7];
            write_cfg(VEC[v][6:3], 4'b0000);
            step(1);
            chk($sformatf("R2/R5/R6 vec %0d req", v), irq_req, VEC[v][2]);
            if (VEC[v][2]) begin
                chk($sformatf("R6 vec %0d idx", v), irq_idx, VEC[v][1:0]);
            end
        end

        // R2 latency: one edge is not enough
        pin_n = 4'b1111;
        write_cfg(4'b0000, 4'b0000);
        step(2);
        pin_n = 4'b1011;
        step(1);
        chk("R2 not yet after one edge", irq_req, 0);
        step(1);
        chk("R2 request after two edges", irq_req, 1);
        pin_n = 4'b1111;
        step(2);

        // R3 edge mode
        write_cfg(4'b0000, 4'b1111);
        step(2);
        chk("R3 no spurious edge request", irq_req, 0);
        pin_n = 4'b1011;
        step(1);
        pin_n = 4'b1111;
        step(1);
        chk("R3 not yet after two edges", irq_req, 0);
        step(1);
        chk("R3 edge request after three edges", irq_req, 1);
        chk("R3 edge index C", irq_idx, 2);
        step(5);
        chk("R3 edge pending sticky", irq_req, 1);
        pulse_ack(2'd1);
        chk("R4 ack other line keeps pending", irq_req, 1);
        chk("R4 index still C", irq_idx, 2);
        pulse_ack(2'd2);
        chk("R4 ack clears pending", irq_req, 0);

        // R5 masked edge recorded
        write_cfg(4'b0010, 4'b1111);
        pin_n = 4'b1101;
        step(1);
        pin_n = 4'b1111;
        step(3);
        chk("R5 masked edge raises no request", irq_req, 0);
        write_cfg(4'b0000, 4'b1111);
        chk("R5 recorded edge appears on unmask", irq_req, 1);
        chk("R5 index B", irq_idx, 1);
        pulse_ack(2'd1);
        chk("R4 ack B clears", irq_req, 0);

        // R4 level mode ignores ack
        write_cfg(4'b0000, 4'b0000);
        pin_n = 4'b0111;
        step(2);
        chk("R4 level D request", irq_idx, 3);
        pulse_ack(2'd3);
        step(1);
        chk("R4 ack ignored in level mode", irq_req, 1);
        chk("R4 level index D", irq_idx, 3);
        pin_n = 4'b1111;
        step(3);

        // R8 wake
        write_cfg(4'b1111, 4'b0000);
        stop_state = 1'b1;
        pin_n = 4'b1101;
        step(4);
        chk("R8 pin B does not wake", wake, 0);
        pin_n = 4'b1110;
        step(2);
        chk("R8 wake not yet", wake, 0);
        step(1);
        chk("R8 wake with pin A low while masked", wake, 1);
        pin_n = 4'b1111;
        step(4);
        chk("R8 wake held after pin release", wake, 1);
        stop_state = 1'b0;
        step(1);
        chk("R8 wake drops after stop exits", wake, 0);
        pin_n = 4'b1110;
        step(4);
        chk("R8 no wake outside stop", wake, 0);
        chk("R1 mode still frozen", mode_q, 4'b1001);

        finish_run();
    end
endmodule